// File: doc/BRIEF.md
# Oversampled UART Receive Data Recovery

This block is the bit-recovery front end of a serial receiver. It runs on an external receiver-time tick enable that pulses sixteen times per bit period. The block looks for a qualified falling edge that marks a start bit and checks that start bit. When noise hits the start bit, it drops the attempt and goes back to searching. For each data bit it takes a majority vote of three samples near the middle of the bit. Data bits arrive least-significant bit first, and the stop bit is checked last. Each completed frame produces a byte and a one-clock ready pulse. A noise flag and a framing-error flag hold their value until a clear pulse.

The surrounding receiver supplies the tick from its baud generator. It feeds `rxd_i` already synchronised to `clk_i`. It takes `data_o` on the clock where `rdy_o` is high. Between ticks the block keeps its state and does nothing.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, `rdy_o`, `noise_o` and `fe_o` are 0 and `data_o` is all zeros.
- R2: While searching, a low sample on a tick starts a frame only if the three sampled ticks just before it were all high. That low sample is RT1 of the start bit. Any other low sample starts nothing.
- R3: If the start-bit sample at RT3 is high, the frame attempt is dropped and the search resumes. That high sample counts as the first of the three highs needed for the next edge.
- R4: If the start-bit samples at RT3, RT5 and RT7 have a high majority, the frame is abandoned at RT7 without setting the noise flag. The RT7 high sample counts as the first of the three highs for the next edge. The start bit never uses samples at RT8 to RT10.
- R5: Each of the 8 data bits, and the stop bit, takes the majority of its samples at RT8, RT9 and RT10. Data bits arrive least-significant bit first. Bit periods are 16 ticks and follow one another with no resynchronisation.
- R6: `noise_o` is set when the three voting samples of a data bit or the stop bit disagree. It is also set when a start bit that is kept has disagreeing samples at RT3, RT5 and RT7. The frame timing continues unchanged.
- R7: `fe_o` is set when the stop-bit majority is low. A break, where the line stays low through the stop position, also sets it and delivers `data_o` = 0x00.
- R8: `data_o` and a newly set `fe_o` change in the same clock as the `rdy_o` pulse of their frame. At no other time does `data_o` change.
- R9: `noise_o` and `fe_o` stay set until `clr_i` is high for one clock, which clears both. A set in that same clock takes priority over the clear.
- R10: After the stop-bit decision at RT10, the search starts with an empty history. A new edge needs three fresh high samples, so a line still low after the frame, or high for only two ticks, starts nothing.
- R11: `rdy_o` is a single-clock pulse. It appears in the clock after the tick that carried the stop bit's RT10 sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Receiver-time tick enable, 16 per bit period |
| rxd_i | input | 1 | Serial line, already synchronised |
| clr_i | input | 1 | One-clock clear of noise and framing-error flags |
| data_o | output | DATA_W | Last received byte |
| rdy_o | output | 1 | One-clock pulse when a frame completes |
| noise_o | output | 1 | Sticky noise flag |
| fe_o | output | 1 | Sticky framing-error flag |

## Verification
The bench drives a low line right after reset and again after a frame, with fewer than three highs before it. A design that qualifies edges too loosely would produce phantom frames there. It injects a high at RT3 and a high RT5/RT7 majority in the start bit, then places a clean frame immediately after. A design that does not restart, or that restarts with the wrong history, decodes a shifted byte or misses that frame. Single flipped mid-bit samples check that the noise flag rises while the byte stays correct. Breaks and low stop bits check that the framing error rises together with the ready pulse. Random frames with scattered sample flips are then compared tick by tick against a bench model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_FRAME  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rx_edge_qual.sv
module rx_edge_qual #(
  parameter int HIST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              load_i,
  input  logic [HIST_W-1:0] load_val_i,
  output logic              hist_full_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (load_i)  hist_q <= load_val_i;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], sample_i};
  end

  assign hist_full_o = &hist_q;
endmodule

// File: rtl/rx_bit_vote.sv
module rx_bit_vote #(
  parameter int N_CAP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CAP-1:0] cap_i,
  input  logic             sample_i,
  output logic             maj_o,
  output logic             split_o
);
  logic [N_CAP-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else begin
      for (int i = 0; i < N_CAP; i++)
        if (cap_i[i]) v_q[i] <= sample_i;
    end
  end

  // third vote is the live sample on the deciding tick
  assign maj_o   = (v_q[0] & v_q[1]) | (v_q[0] & sample_i) | (v_q[1] & sample_i);
  assign split_o = !((v_q[0] == v_q[1]) && (v_q[1] == sample_i));
endmodule

// File: rtl/rx_rt_counter.sv
module rx_rt_counter #(
  parameter int OSR   = 16,
  parameter int NBITS = 10,
  localparam int RT_W  = $clog2(OSR + 1),
  localparam int BIT_W = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [RT_W-1:0]  rt_nxt_o,
  output logic [BIT_W-1:0] bit_nxt_o
);
  logic [RT_W-1:0]  rt_q;
  logic [BIT_W-1:0] bit_q;
  logic             wrap;

  always_comb begin
    wrap      = (rt_q == RT_W'(OSR));
    rt_nxt_o  = wrap ? RT_W'(1) : rt_q + RT_W'(1);
    bit_nxt_o = wrap ? bit_q + BIT_W'(1) : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_q  <= RT_W'(1);
      bit_q <= '0;
    end else if (start_i) begin
      rt_q  <= RT_W'(1);
      bit_q <= '0;
    end else if (adv_i) begin
      rt_q  <= rt_nxt_o;
      bit_q <= bit_nxt_o;
    end
  end
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int START_P0 = 3,
  parameter int START_P1 = 5,
  parameter int START_P2 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              noise_o,
  output logic              fe_o
);
  localparam int NBITS  = DATA_W + 2;
  localparam int RT_W   = $clog2(OSR + 1);
  localparam int BIT_W  = $clog2(NBITS + 1);
  localparam int HIST_W = 3;
  localparam logic [RT_W-1:0] MID_P0 = RT_W'(OSR / 2);
  localparam logic [RT_W-1:0] MID_P1 = RT_W'(OSR / 2 + 1);
  localparam logic [RT_W-1:0] MID_P2 = RT_W'(OSR / 2 + 2);
  localparam logic [RT_W-1:0] STA_P0 = RT_W'(START_P0);
  localparam logic [RT_W-1:0] STA_P1 = RT_W'(START_P1);
  localparam logic [RT_W-1:0] STA_P2 = RT_W'(START_P2);

  rx_state_e         state_q;
  logic [RT_W-1:0]   rt_nxt;
  logic [BIT_W-1:0]  bit_nxt;
  logic [DATA_W-1:0] shreg_q;
  logic              hist_full, maj, split;
  logic              in_frame, adv, is_start, is_stop;
  logic [RT_W-1:0]   pos0, pos1, pos2;
  logic [1:0]        cap;
  logic              decide, edge_hit, early_noise, start_abort;
  logic              stop_done, data_take, restart, noise_set, fe_set;
  logic              hist_load;
  logic [HIST_W-1:0] hist_val;

  always_comb begin
    in_frame    = (state_q == ST_FRAME);
    adv         = tick_i & in_frame;
    is_start    = (bit_nxt == '0);
    is_stop     = (bit_nxt == BIT_W'(NBITS - 1));
    pos0        = is_start ? STA_P0 : MID_P0;
    pos1        = is_start ? STA_P1 : MID_P1;
    pos2        = is_start ? STA_P2 : MID_P2;
    cap[0]      = adv & (rt_nxt == pos0);
    cap[1]      = adv & (rt_nxt == pos1);
    decide      = adv & (rt_nxt == pos2);
    edge_hit    = tick_i & ~in_frame & ~rxd_i & hist_full;
    early_noise = adv & is_start & (rt_nxt == STA_P0) & rxd_i;
    start_abort = decide & is_start & maj;
    stop_done   = decide & is_stop;
    data_take   = decide & ~is_start & ~is_stop;
    restart     = early_noise | start_abort;
    noise_set   = decide & split & ~start_abort;
    fe_set      = stop_done & ~maj;
    hist_load   = restart | stop_done;
    // restart seeds one high sample; frame end starts from an empty history
    hist_val    = restart ? HIST_W'(1) : '0;
  end

  rx_edge_qual #(.HIST_W(HIST_W)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (tick_i & ~in_frame),
    .sample_i   (rxd_i),
    .load_i     (hist_load),
    .load_val_i (hist_val),
    .hist_full_o(hist_full)
  );

  rx_rt_counter #(.OSR(OSR), .NBITS(NBITS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (edge_hit),
    .adv_i    (adv),
    .rt_nxt_o (rt_nxt),
    .bit_nxt_o(bit_nxt)
  );

  rx_bit_vote #(.N_CAP(2)) u_vote (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .sample_i(rxd_i),
    .maj_o   (maj),
    .split_o (split)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      shreg_q <= '0;
      data_o  <= '0;
      rdy_o   <= 1'b0;
      noise_o <= 1'b0;
      fe_o    <= 1'b0;
    end else begin
      rdy_o <= stop_done;
      if (edge_hit)                  state_q <= ST_FRAME;
      else if (restart || stop_done) state_q <= ST_SEARCH;
      if (data_take) shreg_q <= {maj, shreg_q[DATA_W-1:1]};
      if (stop_done) data_o <= shreg_q;
      if (noise_set)  noise_o <= 1'b1;
      else if (clr_i) noise_o <= 1'b0;
      if (fe_set)     fe_o <= 1'b1;
      else if (clr_i) fe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              rdy_o,
  input logic              noise_o,
  input logic              fe_o
);
  AST_RDY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o); // R11
  AST_RDY_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> $past(tick_i)); // R11
  AST_FE_RISE_WITH_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_o) |-> rdy_o); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> $stable(data_o)); // R8
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !clr_i) |=> fe_o); // R9
  AST_NOISE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_o && !clr_i) |=> noise_o); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> (!fe_o && !noise_o)); // R9
endmodule

bind uart_rx_recover uart_rx_recover_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .clr_i  (clr_i),
  .data_o (data_o),
  .rdy_o  (rdy_o),
  .noise_o(noise_o),
  .fe_o   (fe_o)
);

// File: tb/uart_rx_recover_test.sv
module uart_rx_recover_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] data;
  logic       rdy, noise, fe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // observations
  int         obs_cnt = 0;
  logic [7:0] obs_data;
  logic       obs_fe, obs_fe_pre;
  logic       pend_clr = 1'b0;

  // bench model state
  bit         m_frame = 0;
  logic [2:0] m_hist = 3'b000;
  int         m_rt = 1, m_bit = 0;
  logic       m_a = 0, m_b = 0;
  logic [7:0] m_sh = '0, m_data = '0;
  logic       m_rdy = 0, m_fe = 0, m_noise = 0;

  uart_rx_recover uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .clr_i(clr),
    .data_o(data), .rdy_o(rdy), .noise_o(noise), .fe_o(fe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic model_tick(input logic s);
    logic mj, sp;
    m_rdy = 0;
    if (!m_frame) begin
      if (!s && m_hist == 3'b111) begin
        m_frame = 1; m_rt = 1; m_bit = 0;
      end
      m_hist = {m_hist[1:0], s};
    end else begin
      m_rt++;
      if (m_rt > 16) begin m_rt = 1; m_bit++; end
      if (m_bit == 0) begin
        if (m_rt == 3) begin
          m_a = s;
          if (s) begin m_frame = 0; m_hist = 3'b001; end
        end else if (m_rt == 5) m_b = s;
        else if (m_rt == 7) begin
          mj = maj3(m_a, m_b, s);
          sp = !(m_a == m_b && m_b == s);
          if (mj) begin m_frame = 0; m_hist = 3'b001; end
          else if (sp) m_noise = 1;
        end
      end else begin
        if (m_rt == 8) m_a = s;
        else if (m_rt == 9) m_b = s;
        else if (m_rt == 10) begin
          mj = maj3(m_a, m_b, s);
          sp = !(m_a == m_b && m_b == s);
          if (sp) m_noise = 1;
          if (m_bit <= 8) m_sh = {mj, m_sh[7:1]};
          else begin
            m_data = m_sh; m_rdy = 1;
            if (!mj) m_fe = 1;
            m_frame = 0; m_hist = 3'b000;
          end
        end
      end
    end
  endtask

  // one RT tick (two clocks); entered and left at a falling edge
  task automatic step(input logic v);
    logic fe_pre;
    fe_pre = fe;
    rxd = v; tick = 1'b1; clr = 1'b0;
    @(negedge clk);
    model_tick(v);
    tick = 1'b0;
    chk(rdy == m_rdy, "R11 rdy pulse", rdy, m_rdy);
    chk(data == m_data, "R5 data", data, m_data);
    chk(fe == m_fe, "R7 fe", fe, m_fe);
    chk(noise == m_noise, "R6 noise", noise, m_noise);
    if (rdy) begin
      obs_cnt++; obs_data = data; obs_fe = fe; obs_fe_pre = fe_pre;
    end
    clr = pend_clr;
    @(negedge clk);
    if (pend_clr) begin m_fe = 0; m_noise = 0; end
    pend_clr = 1'b0;
    clr = 1'b0;
    chk(rdy == 1'b0, "R11 rdy one clock", rdy, 0);
  endtask

  task automatic steps(input logic v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  // start + 8 data + stop, 16 ticks each; one optional flipped sample
  task automatic send_frame(input logic [7:0] b, input logic stopv,
                            input int flip_pos, input bit rnd);
    for (int p = 0; p < 160; p++) begin
      int bp;
      logic v;
      bp = p / 16;
      if (bp == 0) v = 1'b0;
      else if (bp <= 8) v = b[bp-1];
      else v = stopv;
      if (p == flip_pos) v = ~v;
      if (rnd && ($urandom % 50 == 0)) v = ~v;
      step(v);
    end
  endtask

  task automatic expect_frame(input int cnt0, input logic [7:0] exp_d,
                              input logic exp_fe, input string tag);
    chk(obs_cnt == cnt0 + 1, {tag, " frame count"}, obs_cnt, cnt0 + 1);
    chk(obs_data == exp_d, {tag, " byte"}, obs_data, exp_d);
    chk(obs_fe == exp_fe, {tag, " fe at ready"}, obs_fe, exp_fe);
  endtask

  task automatic do_clear();
    pend_clr = 1'b1;
    step(1'b1);
    chk(fe == 1'b0 && noise == 1'b0, "R9 clear", {fe, noise}, 0);
  endtask

  initial begin
    int c0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rdy == 0 && fe == 0 && noise == 0 && data == 8'h00, "R1 reset",
        {data, rdy, fe, noise}, 0);

    // R2: only two highs before a low
    c0 = obs_cnt;
    steps(1'b1, 2); steps(1'b0, 200);
    chk(obs_cnt == c0, "R2 unqualified low", obs_cnt, c0);

    // R7/R8: break
    c0 = obs_cnt;
    steps(1'b1, 3); steps(1'b0, 160);
    expect_frame(c0, 8'h00, 1'b1, "R7 break");
    chk(obs_fe_pre == 1'b0, "R8 fe rises with ready", obs_fe_pre, 0);

    // R10: line low after frame, then only two highs
    c0 = obs_cnt;
    steps(1'b1, 2); steps(1'b0, 170);
    chk(obs_cnt == c0, "R10 fresh history", obs_cnt, c0);

    // R9: flag held, then cleared
    steps(1'b1, 5);
    chk(fe == 1'b1, "R9 fe sticky", fe, 1);
    do_clear();

    // R5: clean frame
    c0 = obs_cnt;
    steps(1'b1, 4); send_frame(8'hA5, 1'b1, -1, 0);
    expect_frame(c0, 8'hA5, 1'b0, "R5 clean");
    chk(noise == 1'b0, "R5 clean noise", noise, 0);

    // R3: high at start RT3, then two highs and a real frame
    c0 = obs_cnt;
    steps(1'b1, 4); steps(1'b0, 2); steps(1'b1, 3);
    send_frame(8'h81, 1'b1, -1, 0);
    expect_frame(c0, 8'h81, 1'b0, "R3 restart");

    // R4: RT5/RT7 high majority abandons the start bit
    c0 = obs_cnt;
    steps(1'b1, 4); steps(1'b0, 4); steps(1'b1, 3);
    chk(obs_cnt == c0 && noise == 1'b0, "R4 abandon no noise", noise, 0);
    steps(1'b1, 2);
    send_frame(8'h5A, 1'b1, -1, 0);
    expect_frame(c0, 8'h5A, 1'b0, "R4 next frame");

    // R6: one flipped mid sample in data bit 2 (frame bit 3, RT9)
    c0 = obs_cnt;
    steps(1'b1, 4); send_frame(8'h33, 1'b1, 3*16 + 8, 0);
    expect_frame(c0, 8'h33, 1'b0, "R6 noisy bit");
    chk(noise == 1'b1, "R6 noise set", noise, 1);
    c0 = obs_cnt;
    steps(1'b1, 4); send_frame(8'h0F, 1'b1, -1, 0);
    expect_frame(c0, 8'h0F, 1'b0, "R9 next frame");
    chk(noise == 1'b1, "R9 noise sticky", noise, 1);
    do_clear();

    // R7: low stop bit
    c0 = obs_cnt;
    steps(1'b1, 4); send_frame(8'hF0, 1'b0, -1, 0);
    expect_frame(c0, 8'hF0, 1'b1, "R7 low stop");
    chk(obs_fe_pre == 1'b0, "R8 fe with ready", obs_fe_pre, 0);
    steps(1'b1, 4);
    do_clear();

    // random frames, model compared every tick
    for (int f = 0; f < 150; f++) begin
      logic [7:0] b;
      logic sv;
      int idle;
      b = 8'($urandom);
      sv = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) begin b = 8'h00; sv = 1'b0; end
      idle = 3 + int'($urandom % 6);
      for (int i = 0; i < idle; i++) step(($urandom % 50 == 0) ? 1'b0 : 1'b1);
      if ($urandom % 20 == 0) pend_clr = 1'b1;
      send_frame(b, sv, -1, 1);
    end
    steps(1'b1, 8);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule